// File: doc/BRIEF.md
# Single-Precision Min/Max and Compare Unit

This block takes two single-precision floating-point operands and an operation code and returns one result a single clock cycle later. Four operations pick a minimum or a maximum. The other four are ordered comparisons whose boolean answer is zero-extended to 32 bits. A valid bit travels alongside the operands and comes out with the registered result. An invalid-operation flag is raised according to the NaN rules of each operation.

Two modifier settings change how NaN operands are handled. The first switches minimum and maximum from the older number-preferring behaviour to the 2019 behaviour, in which any NaN input produces the canonical NaN. The second makes the compares quiet, so that a quiet NaN operand no longer raises the invalid flag. Register access, instruction decoding and other precisions stay outside the block.

Top module: `fpmm_unit`

## Requirements
- R1: `out_valid` equals `in_valid` from one clock edge earlier. `out_result` and `out_invalid` belong to the operation that was accepted on that edge. A synchronous reset clears `out_valid`, `out_result` and `out_invalid` to 0.
- R2: `in_op` encodes the operation as follows. Bit 2 selects compare (1) or min/max (0). Bit 1 is the modifier: the 2019 variant for min/max, the quiet variant for compares. Bit 0 selects max, or less-or-equal (1), against min, or less-than (0). The eight codes are: 000 min, 001 max, 010 min-2019, 011 max-2019, 100 lt, 101 le, 110 quiet lt, 111 quiet le.
- R3: With two non-NaN operands, min returns the smaller operand and max returns the larger, bit-exact. Negative zero counts as smaller than positive zero.
- R4: The legacy min/max (codes 000, 001) return the other operand when exactly one input is NaN. When both inputs are NaN they return 0x7FC00000.
- R5: The 2019 min/max (codes 010, 011) return 0x7FC00000 when either input is any NaN. Otherwise they behave as in R3.
- R6: The signaling compares (codes 100, 101) return 1 or 0 in bit 0, with bits 31:1 zero. Negative zero and positive zero compare equal. If any operand is NaN, the result is 0 and `out_invalid` is 1.
- R7: The quiet compares (codes 110, 111) return the same value as the signaling compares for every input. They raise `out_invalid` only when a signaling NaN is present.
- R8: A signaling NaN operand raises `out_invalid` in every operation. A NaN is a value with an all-ones exponent and a non-zero mantissa; it is signaling when mantissa bit 22 is 0. A quiet NaN in min/max does not raise invalid, and two non-NaN operands never raise it.
- R9: While `in_valid` is 0, `out_result` and `out_invalid` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| in_op | input | 3 | Operation code (see R2) |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result is valid |
| out_result | output | 32 | Min/max value or zero-extended compare bit |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The bench aims at the signed-zero pairs. If the ordering and the equality paths were mixed up, min(+0,−0) would return +0, or lt(−0,+0) would return 1. It mixes quiet and signaling NaNs into every operation. A unit that raised invalid on quiet NaNs in the quiet compares, or that passed a NaN through the 2019 min/max instead of canonicalising it, gives a flag or result that differs from the reference. It also checks the legacy one-NaN case, which must return the other operand bit-exact, and negative operands, where magnitude order is reversed. A comparator that skipped the reversal would swap min and max.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int OP_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_MIN    = 3'b000,
        OP_MAX    = 3'b001,
        OP_MIN19  = 3'b010,
        OP_MAX19  = 3'b011,
        OP_LT     = 3'b100,
        OP_LE     = 3'b101,
        OP_LT_Q   = 3'b110,
        OP_LE_Q   = 3'b111
    } fpmm_op_e;

    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_nan;
        logic is_snan;
    } fp_class_t;

    function automatic logic op_is_cmp(input logic [OP_W-1:0] op);
        return op[2];
    endfunction

    function automatic logic op_modifier(input logic [OP_W-1:0] op);
        return op[1];
    endfunction

    function automatic logic op_upper(input logic [OP_W-1:0] op);
        return op[0];
    endfunction
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
    import fpmm_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int MW = MAN_W,
    localparam int W = EW + MW + 1
) (
    input  logic [W-1:0] value,
    output fp_class_t    cls
);
    logic [EW-1:0] exp_f;
    logic [MW-1:0] man_f;

    always_comb begin
        exp_f       = value[W-2 -: EW];
        man_f       = value[MW-1:0];
        cls.sign    = value[W-1];
        cls.is_zero = (exp_f == '0) && (man_f == '0);
        cls.is_nan  = (exp_f == '1) && (man_f != '0);
        cls.is_snan = cls.is_nan && !man_f[MW-1];
    end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_zero,
    input  logic         b_zero,
    output logic         lt_total,
    output logic         lt_num,
    output logic         eq_num
);
    logic [W-2:0] mag_a, mag_b;
    logic         mag_lt, mag_gt, both_zero;

    always_comb begin
        mag_a     = a[W-2:0];
        mag_b     = b[W-2:0];
        mag_lt    = mag_a < mag_b;
        mag_gt    = mag_b < mag_a;
        both_zero = a_zero && b_zero;
        if (a[W-1] != b[W-1])
            lt_total = a[W-1];
        else if (!a[W-1])
            lt_total = mag_lt;
        else
            lt_total = mag_gt;
        lt_num = both_zero ? 1'b0 : lt_total;
        eq_num = both_zero || (a == b);
    end
endmodule

// File: rtl/fpmm_decide.sv
module fpmm_decide
    import fpmm_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int MW = MAN_W,
    localparam int W = EW + MW + 1
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            a_nan,
    input  logic            b_nan,
    input  logic            a_snan,
    input  logic            b_snan,
    input  logic            lt_total,
    input  logic            lt_num,
    input  logic            eq_num,
    output logic [W-1:0]    result,
    output logic            invalid
);
    localparam logic [W-1:0] CANON = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

    logic any_nan, any_snan, cmp_bit, pick_a;

    always_comb begin
        any_nan  = a_nan || b_nan;
        any_snan = a_snan || b_snan;
        cmp_bit  = op_upper(op) ? (lt_num || eq_num) : lt_num;
        pick_a   = op_upper(op) ? !lt_total : lt_total;
        if (op_is_cmp(op)) begin
            result  = {{(W-1){1'b0}}, (!any_nan && cmp_bit)};
            invalid = any_snan || (!op_modifier(op) && any_nan);
        end else begin
            invalid = any_snan;
            if ((op_modifier(op) && any_nan) || (a_nan && b_nan))
                result = CANON;
            else if (a_nan)
                result = b;
            else if (b_nan)
                result = a;
            else
                result = pick_a ? a : b;
        end
    end
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
    import fpmm_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int MW = MAN_W,
    localparam int W = EW + MW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_op,
    input  logic [W-1:0]    in_a,
    input  logic [W-1:0]    in_b,
    output logic            out_valid,
    output logic [W-1:0]    out_result,
    output logic            out_invalid
);
    localparam logic [W-1:0] CANON = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

    fp_class_t     cls_a, cls_b;
    logic          lt_total, lt_num, eq_num;
    logic [W-1:0]  nxt_result;
    logic          nxt_invalid;

    fpmm_classify #(.EW(EW), .MW(MW)) u_cls_a (.value(in_a), .cls(cls_a));
    fpmm_classify #(.EW(EW), .MW(MW)) u_cls_b (.value(in_b), .cls(cls_b));

    fpmm_order #(.W(W)) u_order (
        .a(in_a), .b(in_b),
        .a_zero(cls_a.is_zero), .b_zero(cls_b.is_zero),
        .lt_total(lt_total), .lt_num(lt_num), .eq_num(eq_num)
    );

    fpmm_decide #(.EW(EW), .MW(MW)) u_decide (
        .op(in_op), .a(in_a), .b(in_b),
        .a_nan(cls_a.is_nan), .b_nan(cls_b.is_nan),
        .a_snan(cls_a.is_snan), .b_snan(cls_b.is_snan),
        .lt_total(lt_total), .lt_num(lt_num), .eq_num(eq_num),
        .result(nxt_result), .invalid(nxt_invalid)
    );

    logic sign_unused;
    assign sign_unused = cls_a.sign ^ cls_b.sign;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= nxt_result;
                out_invalid <= nxt_invalid;
            end
        end
    end

    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_invalid)));
    // R6
    cmp_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[2]) |=> (out_result[W-1:1] == '0));
    // R5
    ieee_nan_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op[2] && in_op[1] && (cls_a.is_nan || cls_b.is_nan))
        |=> (out_result == CANON));
    // R6
    sig_nan_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[2] && !in_op[1] && (cls_a.is_nan || cls_b.is_nan))
        |=> (out_invalid && out_result == '0));
    // R7
    quiet_no_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[2] && in_op[1] && !cls_a.is_snan && !cls_b.is_snan)
        |=> !out_invalid);
    // R8
    snan_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (cls_a.is_snan || cls_b.is_snan)) |=> out_invalid);
    // R4
    legacy_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[2:1] == 2'b00 && cls_a.is_nan && !cls_b.is_nan)
        |=> (out_result == $past(in_b)));
endmodule

// File: tb/fpmm_unit_tb.sv
module fpmm_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CANON = 32'h7FC0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [31:0] in_a = '0, in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpmm_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_result(out_result), .out_invalid(out_invalid)
    );

    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic bit is_snan(input logic [31:0] x);
        return is_nan(x) && !x[22];
    endfunction
    function automatic logic [31:0] okey(input logic [31:0] x, input bit merge_zero);
        if (merge_zero && x[30:0] == 0) return 32'h8000_0000;
        return x[31] ? ~x : (x | 32'h8000_0000);
    endfunction

    function automatic logic [31:0] exp_res(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] ka, kb;
        bit an, bn;
        an = is_nan(a); bn = is_nan(b);
        if (op[2]) begin
            if (an || bn) return 32'h0;
            ka = okey(a, 1); kb = okey(b, 1);
            return op[0] ? {31'h0, ka <= kb} : {31'h0, ka < kb};
        end
        if (an && bn) return CANON;
        if (op[1] && (an || bn)) return CANON;
        if (an) return b;
        if (bn) return a;
        ka = okey(a, 0); kb = okey(b, 0);
        if (op[0]) return (ka < kb) ? b : a;
        return (ka < kb) ? a : b;
    endfunction

    function automatic bit exp_inv(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        if (is_snan(a) || is_snan(b)) return 1'b1;
        return op[2] && !op[1] && (is_nan(a) || is_nan(b));
    endfunction

    function automatic string req_of(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        if (is_snan(a) || is_snan(b)) return "R8";
        if (op[2]) return op[1] ? "R7" : "R6";
        if (op[1]) return "R5";
        if (is_nan(a) || is_nan(b)) return "R4";
        return "R3";
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, expv);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        bit ei;
        string rq;
        er = exp_res(op, a, b);
        ei = exp_inv(op, a, b);
        rq = req_of(op, a, b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_a = $urandom; in_b = $urandom; in_op = 3'($urandom);
        chk("R1", "out_valid", {31'h0, out_valid}, 32'h1);
        chk(rq, $sformatf("result op=%0b a=%08h b=%08h", op, a, b), out_result, er);
        chk(rq, $sformatf("invalid op=%0b a=%08h b=%08h", op, a, b), {31'h0, out_invalid}, {31'h0, ei});
    endtask

    task automatic chk_hold();
        logic [31:0] r;
        logic f;
        r = out_result; f = out_invalid;
        @(negedge clk);
        chk("R1", "idle out_valid", {31'h0, out_valid}, 32'h0);
        chk("R9", "held result", out_result, r);
        chk("R9", "held invalid", {31'h0, out_invalid}, {31'h0, f});
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 11))
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7FC0_0001;
            3: return 32'hFF80_0001;
            4: return 32'h7F80_0000;
            5: return 32'hFF80_0000;
            6: return 32'h3F80_0000;
            7: return 32'hBF80_0000;
            8: return {1'b0, 8'hFF, 1'b0, 22'($urandom_range(1, 4194303))};
            default: return $urandom;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1", "reset out_valid", {31'h0, out_valid}, 32'h0);
        chk("R1", "reset out_result", out_result, 32'h0);
        chk("R1", "reset out_invalid", {31'h0, out_invalid}, 32'h0);
        rst = 1'b0;

        // R3 signed zeros and negatives (R2 codes 000/001)
        run_op(3'b000, 32'h0000_0000, 32'h8000_0000);
        run_op(3'b001, 32'h8000_0000, 32'h0000_0000);
        run_op(3'b000, 32'hC000_0000, 32'hBF80_0000);
        run_op(3'b001, 32'hC000_0000, 32'hBF80_0000);
        // R4 legacy NaN handling
        run_op(3'b000, 32'h7FC0_0000, 32'h4040_0000);
        run_op(3'b001, 32'h4040_0000, 32'h7FC1_2345);
        run_op(3'b000, 32'h7FC1_0000, 32'hFFC0_0002);
        // R5 2019 variants
        run_op(3'b010, 32'h7FC0_0000, 32'h4040_0000);
        run_op(3'b011, 32'h3F80_0000, 32'h7F80_0001);
        run_op(3'b010, 32'h8000_0000, 32'h0000_0000);
        // R6 signaling compares with zeros and NaN
        run_op(3'b100, 32'h8000_0000, 32'h0000_0000);
        run_op(3'b101, 32'h8000_0000, 32'h0000_0000);
        run_op(3'b100, 32'h7FC0_0000, 32'h3F80_0000);
        // R7 quiet compares
        run_op(3'b110, 32'h7FC0_0000, 32'h3F80_0000);
        run_op(3'b111, 32'hBF80_0000, 32'h3F80_0000);
        // R8 signaling NaN in quiet compare and min
        run_op(3'b111, 32'h3F80_0000, 32'h7F80_0001);
        run_op(3'b000, 32'h7F80_0001, 32'h3F80_0000);
        chk_hold();

        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            a = pick_val();
            b = ($urandom_range(0, 7) == 0) ? a : pick_val();
            run_op(3'($urandom), a, b);
            if (i % 50 == 0) chk_hold();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule